// File: doc/BRIEF.md
# Four-State Bitwise Logic Unit

This block applies one of six two-input bitwise operations to operand vectors in which every bit can hold one of four states: logic 0, logic 1, high impedance or undefined. Each bit travels as a two-bit code split across two parallel planes. The value plane holds the first bit and the unknown plane holds the second. Code 00 is logic 0, 10 is logic 1, 01 is high impedance and 11 is undefined. A 3-bit select chooses the operation. The encoding is 0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 XNOR. Codes 6 and 7 are unused.

The evaluation is combinational and runs per bit lane. A result register captures it on a clock edge where the valid strobe is high. A small controller with two states, `ST_IDLE` and `ST_ISSUE`, produces the output valid. The transition `IDLE->ISSUE` is taken on a strobe. `ISSUE->ISSUE` is taken on a back-to-back strobe. `ISSUE->IDLE` is taken when no strobe arrives. A high-impedance input is treated as unknown, but a controlling value still forces a known result. The unit never produces the high-impedance code.

Top module: `fsl_unit`

## Requirements
- R1: When `in_valid` is high on a rising edge, the result for the operands and select present at that edge appears on `y_val`/`y_unk`, and `out_valid` is high for the following cycle. `out_valid` is low after any edge with `in_valid` low.
- R2: On an edge with `in_valid` low, the result planes keep their previous contents whatever the operands and select are doing.
- R3: AND (select 0): a logic 0 on either input gives 0 (code 00) regardless of the other input. Two logic 1 inputs give 1 (code 10). Every other pair gives undefined (code 11).
- R4: OR (select 1): a logic 1 on either input gives 1 regardless of the other input. Two logic 0 inputs give 0. Every other pair gives undefined.
- R5: XOR (select 2) and XNOR (select 5): any input that is high impedance (01) or undefined (11) gives undefined. Known pairs give the exclusive-or, or its complement for XNOR.
- R6: NAND (select 3) and NOR (select 4) give the complement of AND and OR where those are known, and undefined where they are undefined.
- R7: The high-impedance code 01 never appears on any result bit. Two high-impedance inputs give undefined under all six operations.
- R8: Select codes 6 and 7 load every result bit as undefined.
- R9: A synchronous active-high `rst` clears `out_valid` and sets every result bit to undefined (both planes all ones).
- R10: Behaviour is identical per lane for WIDTH of 1, 32, 33 and 64, including lanes above bit 31. Each lane is evaluated independently of its neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Load strobe for the result register |
| op_sel | input | 3 | Operation select (0 AND, 1 OR, 2 XOR, 3 NAND, 4 NOR, 5 XNOR) |
| a_val | input | WIDTH | Operand A value plane |
| a_unk | input | WIDTH | Operand A unknown plane |
| b_val | input | WIDTH | Operand B value plane |
| b_unk | input | WIDTH | Operand B unknown plane |
| out_valid | output | 1 | High for one cycle after each strobe |
| y_val | output | WIDTH | Result value plane |
| y_unk | output | WIDTH | Result unknown plane |

## Verification
The bench goes after each operation's treatment of the high-impedance and undefined codes. A design that passed high impedance through would show code 01 on the outputs. One that let high impedance act as 0 or 1 would give known results for XOR, or for AND with an input at 1. A design that forgot the controlling value would return undefined for AND with an input at 0.

Every lane receives a different one of the sixteen input pairs at the same time, rotated through all of them. Lanes that leak into each other, or that are miswired above bit 31, therefore disagree with the reference table. Directed tests cover unused select codes, a hold with changing operands, back-to-back strobes and reset in mid-operation. Each of these would expose a stale or missing result, or a stuck valid.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
    typedef logic [1:0] code_t;

    localparam code_t CODE_ZERO = 2'b00;
    localparam code_t CODE_ONE  = 2'b10;
    localparam code_t CODE_HIZ  = 2'b01;
    localparam code_t CODE_UNK  = 2'b11;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_NAND = 3'd3,
        OP_NOR  = 3'd4,
        OP_XNOR = 3'd5
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } vstate_e;
endpackage

// File: rtl/fsl_lane.sv
module fsl_lane
    import fsl_pkg::*;
(
    input  logic [2:0] op_sel,
    input  code_t      a_code,
    input  code_t      b_code,
    output code_t      y_code
);
    logic a_lo, a_hi, b_lo, b_hi;
    logic a_known, b_known;
    code_t and_code, or_code, xor_code;

    // Decode each input into known-0 / known-1; Z and X both count as unknown
    assign a_lo    = (a_code == CODE_ZERO);
    assign a_hi    = (a_code == CODE_ONE);
    assign b_lo    = (b_code == CODE_ZERO);
    assign b_hi    = (b_code == CODE_ONE);
    assign a_known = a_lo | a_hi;
    assign b_known = b_lo | b_hi;

    always_comb begin
        if (a_lo || b_lo)       and_code = CODE_ZERO;
        else if (a_hi && b_hi)  and_code = CODE_ONE;
        else                    and_code = CODE_UNK;

        if (a_hi || b_hi)       or_code = CODE_ONE;
        else if (a_lo && b_lo)  or_code = CODE_ZERO;
        else                    or_code = CODE_UNK;

        if (a_known && b_known) xor_code = (a_hi ^ b_hi) ? CODE_ONE : CODE_ZERO;
        else                    xor_code = CODE_UNK;
    end

    function automatic code_t invert(input code_t c);
        if (c == CODE_ZERO)     return CODE_ONE;
        else if (c == CODE_ONE) return CODE_ZERO;
        else                    return CODE_UNK;
    endfunction

    always_comb begin
        unique case (op_sel)
            OP_AND:  y_code = and_code;
            OP_OR:   y_code = or_code;
            OP_XOR:  y_code = xor_code;
            OP_NAND: y_code = invert(and_code);
            OP_NOR:  y_code = invert(or_code);
            OP_XNOR: y_code = invert(xor_code);
            default: y_code = CODE_UNK;
        endcase
    end
endmodule

// File: rtl/fsl_ctrl.sv
module fsl_ctrl
    import fsl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic load_en,
    output logic out_valid
);
    vstate_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  state_nxt = in_valid ? ST_ISSUE : ST_IDLE;
            ST_ISSUE: state_nxt = in_valid ? ST_ISSUE : ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en   = in_valid & ~rst;
        out_valid = (state == ST_ISSUE);
    end
endmodule

// File: rtl/fsl_rreg.sv
module fsl_rreg #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [WIDTH-1:0] d_val,
    input  logic [WIDTH-1:0] d_unk,
    output logic [WIDTH-1:0] q_val,
    output logic [WIDTH-1:0] q_unk
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_val <= '1;
            q_unk <= '1;
        end else if (load_en) begin
            q_val <= d_val;
            q_unk <= d_unk;
        end
    end
endmodule

// File: rtl/fsl_unit.sv
module fsl_unit
    import fsl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [2:0]       op_sel,
    input  logic [WIDTH-1:0] a_val,
    input  logic [WIDTH-1:0] a_unk,
    input  logic [WIDTH-1:0] b_val,
    input  logic [WIDTH-1:0] b_unk,
    output logic             out_valid,
    output logic [WIDTH-1:0] y_val,
    output logic [WIDTH-1:0] y_unk
);
    logic             load_en;
    logic [WIDTH-1:0] n_val, n_unk;

    fsl_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .load_en   (load_en),
        .out_valid (out_valid)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        code_t yc;
        fsl_lane u_lane (
            .op_sel (op_sel),
            .a_code ({a_val[i], a_unk[i]}),
            .b_code ({b_val[i], b_unk[i]}),
            .y_code (yc)
        );
        assign n_val[i] = yc[1];
        assign n_unk[i] = yc[0];
    end

    fsl_rreg #(.WIDTH(WIDTH)) u_rreg (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .d_val   (n_val),
        .d_unk   (n_unk),
        .q_val   (y_val),
        .q_unk   (y_unk)
    );
endmodule

// File: rtl/fsl_unit_chk.sv
module fsl_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [2:0]       op_sel,
    input logic [WIDTH-1:0] a_val,
    input logic [WIDTH-1:0] a_unk,
    input logic [WIDTH-1:0] b_val,
    input logic [WIDTH-1:0] b_unk,
    input logic             out_valid,
    input logic [WIDTH-1:0] y_val,
    input logic [WIDTH-1:0] y_unk
);
    logic [WIDTH-1:0] a_zero, b_zero, a_one, b_one;
    assign a_zero = ~a_val & ~a_unk;
    assign b_zero = ~b_val & ~b_unk;
    assign a_one  =  a_val & ~a_unk;
    assign b_one  =  b_val & ~b_unk;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(y_val) && $stable(y_unk))); // R2
    AST_AND_FORCE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd0) |=>
            ((($past(a_zero) | $past(b_zero)) & (y_val | y_unk)) == '0)); // R3
    AST_OR_FORCE_ONE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel == 3'd1) |=>
            ((($past(a_one) | $past(b_one)) & ~(y_val & ~y_unk)) == '0)); // R4
    AST_NO_HIZ_OUT: assert property (@(posedge clk) disable iff (rst)
        ((~y_val & y_unk) == '0)); // R7
    AST_BAD_OP_UNK: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel > 3'd5) |=> (&y_val && &y_unk)); // R8
    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!out_valid && &y_val && &y_unk)); // R9
endmodule

bind fsl_unit fsl_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_sel    (op_sel),
    .a_val     (a_val),
    .a_unk     (a_unk),
    .b_val     (b_val),
    .b_unk     (b_unk),
    .out_valid (out_valid),
    .y_val     (y_val),
    .y_unk     (y_unk)
);

// File: tb/sim_fsl_unit.sv
module sim_fsl_unit;
    localparam int CLK_PERIOD = 10;
    localparam int MAXW       = 64;

    // code {val,unk}: 00=0, 10=1, 01=Z, 11=X
    localparam logic [1:0] K0 = 2'b00, K1 = 2'b10, KZ = 2'b01, KX = 2'b11;

    // {a, b, and, or, xor, nand, nor, xnor}
    localparam logic [15:0] TBL [16] = '{
        {KZ, KZ, KX, KX, KX, KX, KX, KX},
        {KZ, KX, KX, KX, KX, KX, KX, KX},
        {KZ, K0, K0, KX, KX, K1, KX, KX},
        {KZ, K1, KX, K1, KX, KX, K0, KX},
        {KX, KZ, KX, KX, KX, KX, KX, KX},
        {KX, KX, KX, KX, KX, KX, KX, KX},
        {KX, K0, K0, KX, KX, K1, KX, KX},
        {KX, K1, KX, K1, KX, KX, K0, KX},
        {K0, KZ, K0, KX, KX, K1, KX, KX},
        {K0, KX, K0, KX, KX, K1, KX, KX},
        {K0, K0, K0, K0, K0, K1, K1, K1},
        {K0, K1, K0, K1, K1, K1, K0, K0},
        {K1, KZ, KX, K1, KX, KX, K0, KX},
        {K1, KX, KX, K1, KX, KX, K0, KX},
        {K1, K0, K0, K1, K1, K1, K0, K0},
        {K1, K1, K1, K1, K0, K0, K0, K1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic [MAXW-1:0] av = '0, au = '0, bv = '0, bu = '0;
    logic [MAXW-1:0] ev, eu;

    logic        ov0, ov1, ov2, ov3;
    logic [32:0] yv0, yu0;
    logic [0:0]  yv1, yu1;
    logic [63:0] yv2, yu2;
    logic [31:0] yv3, yu3;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsl_unit #(.WIDTH(33)) u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .a_val(av[32:0]), .a_unk(au[32:0]), .b_val(bv[32:0]), .b_unk(bu[32:0]),
        .out_valid(ov0), .y_val(yv0), .y_unk(yu0));
    fsl_unit #(.WIDTH(1)) u1 (.clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .a_val(av[0:0]), .a_unk(au[0:0]), .b_val(bv[0:0]), .b_unk(bu[0:0]),
        .out_valid(ov1), .y_val(yv1), .y_unk(yu1));
    fsl_unit #(.WIDTH(64)) u2 (.clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .a_val(av), .a_unk(au), .b_val(bv), .b_unk(bu),
        .out_valid(ov2), .y_val(yv2), .y_unk(yu2));
    fsl_unit #(.WIDTH(32)) u3 (.clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .a_val(av[31:0]), .a_unk(au[31:0]), .b_val(bv[31:0]), .b_unk(bu[31:0]),
        .out_valid(ov3), .y_val(yv3), .y_unk(yu3));

    task automatic chk(input string req, input string what,
                       input logic [MAXW-1:0] gv, input logic [MAXW-1:0] gu,
                       input logic [MAXW-1:0] xv, input logic [MAXW-1:0] xu);
        checks++;
        if (gv !== xv || gu !== xu) begin
            failures++;
            $display("FAIL %s %s: got val=%h unk=%h expected val=%h unk=%h",
                     req, what, gv, gu, xv, xu);
        end
    endtask

    task automatic chk_bit(input string req, input string what,
                           input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
        end
    endtask

    // Compare all four units against ev/eu, each masked to its width
    task automatic chk_all(input string req, input string what);
        chk(req, {what, " w33"}, {31'd0, yv0}, {31'd0, yu0},
            {31'd0, ev[32:0]}, {31'd0, eu[32:0]});
        chk(req, {what, " w1"}, {63'd0, yv1}, {63'd0, yu1},
            {63'd0, ev[0]}, {63'd0, eu[0]});
        chk(req, {what, " w64"}, yv2, yu2, ev, eu);
        chk(req, {what, " w32"}, {32'd0, yv3}, {32'd0, yu3},
            {32'd0, ev[31:0]}, {32'd0, eu[31:0]});
    endtask

    // Lane i gets table entry (i + rot) mod 16; expected for operation op
    task automatic load_rot(input int rot, input int op);
        for (int i = 0; i < MAXW; i++) begin
            logic [15:0] e;
            logic [1:0]  r;
            e = TBL[(i + rot) % 16];
            av[i] = e[15]; au[i] = e[14];
            bv[i] = e[13]; bu[i] = e[12];
            if (op <= 5) r = e[11 - 2*op -: 2];
            else         r = KX;
            ev[i] = r[1]; eu[i] = r[0];
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            3, 4: return "R6";
            default: return "R5";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        ev = '1; eu = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        chk_all("R9", "reset result");
        chk_bit("R9", "reset out_valid", ov0 | ov1 | ov2 | ov3, 1'b0);

        // Table sweep: R10 across widths, R1 valid, R7 no Z
        for (int op = 0; op < 6; op++) begin
            for (int rot = 0; rot < 16; rot++) begin
                load_rot(rot, op);
                op_sel = 3'(op);
                in_valid = 1'b1;
                @(posedge clk);
                @(negedge clk);
                chk_all(req_of(op), $sformatf("op%0d rot%0d R10", op, rot));
                chk_bit("R1", "out_valid after strobe", ov0 & ov1 & ov2 & ov3, 1'b1);
                chk_bit("R7", "no hiz code", |(~yv2 & yu2), 1'b0);
            end
        end

        // R7: all-Z inputs give X under every op
        for (int op = 0; op < 6; op++) begin
            av = '0; au = '1; bv = '0; bu = '1;
            ev = '1; eu = '1;
            op_sel = 3'(op);
            @(posedge clk);
            @(negedge clk);
            chk_all("R7", $sformatf("all-Z op%0d", op));
        end

        // R1: out_valid falls after a cycle without strobe
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk_bit("R1", "out_valid low without strobe", ov0 | ov1 | ov2 | ov3, 1'b0);

        // R2: known result, then change inputs without strobe
        load_rot(0, 0);
        op_sel = 3'd0;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        av = ~av; bu = ~bu; op_sel = 3'd2;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk_all("R2", "hold without strobe");
        chk_bit("R2", "out_valid low during hold", ov2, 1'b0);

        // R8: unused select codes
        for (int op = 6; op < 8; op++) begin
            load_rot(10, op);
            op_sel = 3'(op);
            in_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            chk_all("R8", $sformatf("unused op%0d", op));
        end

        // R9: reset in mid-operation wins over a strobe
        load_rot(10, 0);
        op_sel = 3'd0;
        in_valid = 1'b1;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        ev = '1; eu = '1;
        chk_all("R9", "reset mid-run");
        chk_bit("R9", "out_valid cleared", ov0 | ov1 | ov2 | ov3, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule